// File: doc/BRIEF.md
# Programmable Tapped Delay Line

This block delays a single-bit input stream by a programmable whole number of clock periods and presents the result on a true output and on its complement. An 8-bit code chooses one of 256 delay settings. The delay is a fixed base latency plus one clock period per code count, so a larger code always gives a longer delay.

The data passes through a shift chain. A tap multiplexer picks one stage of that chain, and a registered output stage follows the multiplexer. The code is not captured in a register. It drives the tap select directly, so a new code applies at the next output update. Two active-low enable inputs are meant to be driven together. If either one is high, the outputs are forced to true-low and complement-high. A registered flag reports any edge at which the two enables differ. A synchronous reset clears the whole chain and the output stage.

Top module: `prog_delay_line`

## Requirements
- R1: A bit sampled on `din` at clock edge k appears on `dly_out` right after edge k + BASE_LAT + `sel`, provided both enables are low and no reset occurs in between. BASE_LAT defaults to 2 and is at least 1.
- R2: The delay is monotonic in the code. Raising `sel` by one lengthens the measured input-to-output latency by exactly one clock period, across the full range 0 to 255.
- R3: From the first edge with reset applied onward, `dly_out_n` is always the logical inverse of `dly_out`.
- R4: After any clock edge at which `en_n_a` or `en_n_b` is high, `dly_out` is 0 and `dly_out_n` is 1. The forcing appears one cycle after the enable change.
- R5: After any clock edge at which both enables are low and reset is inactive, `dly_out` equals the chain stage chosen by `sel` as it stood before that edge.
- R6: `sel` is not registered. A change of `sel` before edge n selects the new tap for the output value loaded at edge n, even when `sel` changes every cycle.
- R7: At a clock edge with `rst_n` low, every chain stage is cleared, `dly_out` goes to 0, `dly_out_n` goes to 1 and `en_fault` goes to 0. After reset is released, `dly_out` stays 0 until data sampled after the reset reaches the selected tap.
- R8: `en_fault` is 1 after an edge at which `en_n_a` and `en_n_b` differ and reset is inactive. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 1 | Data bit to be delayed |
| sel | input | 8 | Delay code, unlatched, drives the tap select |
| en_n_a | input | 1 | Active-low enable, first copy |
| en_n_b | input | 1 | Active-low enable, second copy |
| dly_out | output | 1 | Delayed data, forced low when disabled |
| dly_out_n | output | 1 | Complement of `dly_out`, forced high when disabled |
| en_fault | output | 1 | Registered flag: enable copies disagreed at the last edge |

## Verification
Each output value loaded at edge n depends on a particular earlier edge. The data value is due BASE_LAT + `sel` edges after it was sampled, using the code present at edge n. The forcing, the disagreement flag and the reset values are all due exactly one edge after the enable or reset level that causes them. The bench records every input at each rising edge in a ring indexed by edge number. It then derives the expected value for edge n arithmetically from that record and from the most recent reset edge. It samples the outputs at the following falling edge, which is the only point at which it compares them. Impulse runs measure the latency in whole edges directly, so the monotonic step of one cycle per code is checked separately from the per-cycle comparison.

// File: rtl/dl_pkg.sv
package dl_pkg;

  // Width of the delay code.
  localparam int CODE_W = 8;

  // Number of distinct delay codes.
  localparam int CODE_CNT = 1 << CODE_W;

  // Chain depth needed for a given base latency.
  function automatic int chain_depth(input int base_lat);
    return base_lat + CODE_CNT - 1;
  endfunction

  // Stage index feeding the output register for a code.
  // The output register adds one edge, so stage j gives a latency of j+1.
  function automatic int tap_index(input int base_lat, input int code);
    return base_lat - 1 + code;
  endfunction

  // Total latency in clock edges for a code.
  function automatic int total_delay(input int base_lat, input int code);
    return base_lat + code;
  endfunction

  // Output pair forced while disabled or in reset.
  typedef struct packed {
    logic q;
    logic qn;
  } out_pair_t;

  localparam out_pair_t IDLE_PAIR = '{q: 1'b0, qn: 1'b1};

endpackage

// File: rtl/dl_shift_chain.sv
module dl_shift_chain #(
  parameter int DEPTH = 257
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  output logic [DEPTH-1:0] stages,
  output logic             head_bit
);

  logic [DEPTH-1:0] chain_q;

  // Stage 0 captures the input.
  always_ff @(posedge clk) begin
    if (!rst_n) chain_q[0] <= 1'b0;
    else        chain_q[0] <= din;
  end

  // Each further stage copies its predecessor.
  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) chain_q[g] <= 1'b0;
      else        chain_q[g] <= chain_q[g-1];
    end
  end

  assign stages   = chain_q;
  assign head_bit = chain_q[0];

endmodule

// File: rtl/dl_tap_select.sv
module dl_tap_select #(
  parameter int DEPTH    = 257,
  parameter int BASE_LAT = 2,
  parameter int CODE_W   = 8
) (
  input  logic [DEPTH-1:0]  stages,
  input  logic [CODE_W-1:0] code,
  output logic              tap_bit
);

  localparam int IDX_W = $clog2(DEPTH);

  logic [IDX_W-1:0] idx;

  // Unlatched: the index follows the code combinationally.
  assign idx     = IDX_W'(dl_pkg::tap_index(BASE_LAT, int'(code)));
  assign tap_bit = stages[idx];

endmodule

// File: rtl/dl_out_stage.sv
module dl_out_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic tap_bit,
  input  logic en_n_a,
  input  logic en_n_b,
  output logic dly_out,
  output logic dly_out_n,
  output logic en_fault
);

  import dl_pkg::*;

  logic      disabled;
  out_pair_t pair_q;
  out_pair_t pair_d;
  logic      fault_q;

  assign disabled = en_n_a | en_n_b;

  always_comb begin
    if (disabled) pair_d = IDLE_PAIR;
    else          pair_d = '{q: tap_bit, qn: ~tap_bit};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pair_q  <= IDLE_PAIR;
      fault_q <= 1'b0;
    end else begin
      pair_q  <= pair_d;
      fault_q <= en_n_a ^ en_n_b;
    end
  end

  assign dly_out   = pair_q.q;
  assign dly_out_n = pair_q.qn;
  assign en_fault  = fault_q;

endmodule

// File: rtl/prog_delay_line.sv
module prog_delay_line #(
  parameter int BASE_LAT = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      din,
  input  logic [dl_pkg::CODE_W-1:0] sel,
  input  logic                      en_n_a,
  input  logic                      en_n_b,
  output logic                      dly_out,
  output logic                      dly_out_n,
  output logic                      en_fault
);

  localparam int DEPTH = dl_pkg::chain_depth(BASE_LAT);

  logic [DEPTH-1:0] stages;
  logic             head_bit;
  logic             tap_bit;

  dl_shift_chain #(.DEPTH(DEPTH)) u_chain (
    .clk      (clk),
    .rst_n    (rst_n),
    .din      (din),
    .stages   (stages),
    .head_bit (head_bit)
  );

  dl_tap_select #(
    .DEPTH    (DEPTH),
    .BASE_LAT (BASE_LAT),
    .CODE_W   (dl_pkg::CODE_W)
  ) u_tap (
    .stages  (stages),
    .code    (sel),
    .tap_bit (tap_bit)
  );

  dl_out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .tap_bit   (tap_bit),
    .en_n_a    (en_n_a),
    .en_n_b    (en_n_b),
    .dly_out   (dly_out),
    .dly_out_n (dly_out_n),
    .en_fault  (en_fault)
  );

endmodule

// File: rtl/prog_delay_line_chk.sv
module prog_delay_line_chk (
  input logic clk,
  input logic rst_n,
  input logic din,
  input logic en_n_a,
  input logic en_n_b,
  input logic head_bit,
  input logic tap_bit,
  input logic dly_out,
  input logic dly_out_n,
  input logic en_fault
);

  // R1
  chain_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (head_bit == $past(din)));

  // R3
  complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_out != dly_out_n));

  // R4
  forced_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_n_a || en_n_b) |=> (!dly_out && dly_out_n));

  // R5
  tap_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n_a && !en_n_b) |=> (dly_out == $past(tap_bit)));

  // R7
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!dly_out && dly_out_n && !en_fault));

  // R8
  enable_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> (en_fault == ($past(en_n_a) != $past(en_n_b))));

endmodule

bind prog_delay_line prog_delay_line_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .din       (din),
  .en_n_a    (en_n_a),
  .en_n_b    (en_n_b),
  .head_bit  (head_bit),
  .tap_bit   (tap_bit),
  .dly_out   (dly_out),
  .dly_out_n (dly_out_n),
  .en_fault  (en_fault)
);

// File: tb/test_prog_delay_line.sv
module test_prog_delay_line;

  localparam int BASE = 2;
  localparam int RING = 1024;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       din = 1'b0;
  logic [7:0] sel = 8'd0;
  logic       en_n_a = 1'b0;
  logic       en_n_b = 1'b0;
  logic       dly_out;
  logic       dly_out_n;
  logic       en_fault;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  int last_rst = -1;
  logic d_log [RING];
  bit done = 0;

  always #4 clk = ~clk;

  prog_delay_line #(.BASE_LAT(BASE)) i_prog_delay_line (
    .clk(clk), .rst_n(rst_n), .din(din), .sel(sel),
    .en_n_a(en_n_a), .en_n_b(en_n_b),
    .dly_out(dly_out), .dly_out_n(dly_out_n), .en_fault(en_fault)
  );

  task automatic check(string req, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at edge %0d: actual %b expected %b", req, cyc - 1, act, exp);
    end
  endtask

  // One clock edge: record inputs, then compare outputs at the falling edge.
  task automatic step(string tag);
    int   n;
    int   a_n;
    int   src;
    logic ok_n;
    logic flt_n;
    logic rst_n_n;
    logic exp_q;
    @(posedge clk);
    n = cyc;
    rst_n_n = rst_n;
    d_log[n % RING] = rst_n ? din : 1'b0;
    if (!rst_n) last_rst = n;
    ok_n  = rst_n && !en_n_a && !en_n_b;
    flt_n = rst_n && (en_n_a != en_n_b);
    a_n   = int'(sel);
    cyc++;
    @(negedge clk);
    src = n - (BASE + a_n);
    if (!ok_n) exp_q = 1'b0;
    else if (src <= last_rst || src < 0) exp_q = 1'b0;
    else exp_q = d_log[src % RING];
    check(tag, dly_out, exp_q);
    // R3 complement relation
    check("R3", dly_out_n, ~dly_out);
    // R8 enable disagreement flag
    check("R8", en_fault, flt_n);
    if (!rst_n_n) begin
      // R7 reset values
      check("R7", dly_out, 1'b0);
      check("R7", dly_out_n, 1'b1);
    end
  endtask

  // Latency of a single pulse for one code (R1, R2).
  task automatic measure(int code, output int lat);
    int p;
    sel = 8'(code);
    din = 1'b0;
    en_n_a = 1'b0;
    en_n_b = 1'b0;
    repeat (BASE + 257) step("R1 R5");
    din = 1'b1;
    p = cyc;
    step("R1 R5");
    din = 1'b0;
    lat = -1;
    for (int k = 0; k < 300; k++) begin
      if (dly_out === 1'b1) begin
        lat = (cyc - 1) - p;
        break;
      end
      step("R1 R5");
    end
  endtask

  initial begin
    int prev_lat;
    int lat;
    int codes [8] = '{0, 1, 2, 63, 127, 128, 254, 255};

    // Reset state (R7)
    rst_n = 1'b0;
    repeat (3) step("R7");
    rst_n = 1'b1;

    // Every code, random data (R1, R5)
    for (int a = 0; a < 256; a++) begin
      sel = 8'(a);
      for (int k = 0; k < 4; k++) begin
        din = 1'($urandom);
        step("R1 R5");
      end
    end

    // Code changes every cycle (R6)
    for (int k = 0; k < 600; k++) begin
      sel = 8'($urandom);
      din = 1'($urandom);
      step("R6");
    end

    // Enable combinations with random data (R4, R8)
    sel = 8'd5;
    for (int k = 0; k < 400; k++) begin
      din = 1'($urandom);
      en_n_a = 1'(($urandom % 4) == 0);
      en_n_b = 1'(($urandom % 4) == 0);
      step("R4");
    end
    en_n_a = 1'b0;
    en_n_b = 1'b0;

    // Impulse latency and monotonic step (R1, R2)
    prev_lat = -1;
    foreach (codes[i]) begin
      measure(codes[i], lat);
      tests++;
      if (lat != BASE + codes[i]) begin
        fails++;
        $display("FAIL R1 code %0d: actual latency %0d expected %0d", codes[i], lat, BASE + codes[i]);
      end
      tests++;
      if (i > 0 && lat - prev_lat != codes[i] - codes[i-1]) begin
        fails++;
        $display("FAIL R2 code %0d: actual step %0d expected %0d", codes[i],
                 lat - prev_lat, codes[i] - codes[i-1]);
      end
      prev_lat = lat;
    end

    // Mid-run reset with a chain full of ones (R7)
    sel = 8'd255;
    din = 1'b1;
    repeat (BASE + 260) step("R1 R5");
    check("R1", dly_out, 1'b1);
    rst_n = 1'b0;
    step("R7");
    rst_n = 1'b1;
    din = 1'b0;
    repeat (BASE + 258) step("R7");
    check("R7", dly_out, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  // Watchdog
  initial begin
    #(8 * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule